// File: doc/BRIEF.md
# Addressing-Form Effective Address Decoder

This block turns the addressing-form byte of an instruction, the optional scale-index-base byte and the optional displacement into an operand descriptor. The descriptor says whether the second operand is a register or memory, gives both 3-bit register fields and the effective address, and says whether the default segment is the stack segment. Bytes come in one per cycle on a valid/ready stream. General register values come from a single read port on an 8-entry register file, addressed by the decoder. Register numbering is 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI.

An address-size flag picks 16-bit or 32-bit address forms. A segment-override flag cancels the stack-segment default. Both flags are sampled when the addressing-form byte is accepted. When the stream is complete, the decoder reads the base register and then the index register. It then raises `done` for one cycle, and all descriptor outputs are valid in that cycle. An `abort` input, like reset, drops any partial decode and returns the block to waiting for a new addressing-form byte.

Top module: `ea_decoder`

## Requirements
- R1: At `done`, `regField` equals bits 5:3 and `rmReg` equals bits 2:0 of the addressing-form byte, and `isMem` is 1 exactly when bits 7:6 (the mode) are not 3.
- R2: Mode 3 is a register operand. No further byte is taken, and at `done`, `isMem`, `useStack` and `effAddr` are all 0.
- R3: With 16-bit addressing, r/m selects the base/index pair: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP (no register when the mode is 0), and 7 BX. Only the low 16 bits of each register are used.
- R4: With 16-bit addressing, mode 1 adds a sign-extended 8-bit displacement, mode 2 adds a 16-bit displacement, and mode 0 with r/m 6 uses a 16-bit displacement alone. The result is truncated to 16 bits, so `effAddr[31:16]` is 0.
- R5: With 16-bit addressing and no override, r/m 2, r/m 3, and r/m 6 with a nonzero mode select the stack segment (`useStack`=1). All other forms do not.
- R6: With 32-bit addressing and r/m other than 4, the address is register[r/m] plus the displacement: sign-extended 8-bit for mode 1, 32-bit for mode 2, none for mode 0. The exception is mode 0 with r/m 5, which uses a 32-bit displacement alone. Sums wrap modulo 2^32.
- R7: With 32-bit addressing, r/m 4 and a memory mode, a scale-index-base byte follows. Its base field is bits 2:0, its index field is bits 5:3 and its scale field is bits 7:6. The address is base + (index << scale) + displacement. An index field of 4 contributes nothing. A base field of 5 with mode 0 replaces the base register with a 32-bit displacement.
- R8: With 32-bit addressing and no override, r/m 5 with a nonzero mode and a scale-index-base byte whose base field is 4 select the stack segment. All other forms do not.
- R9: When `segOverride` is high as the addressing-form byte is accepted, `useStack` is 0 for that decode.
- R10: Bytes are taken in the order addressing-form, scale-index-base, displacement. Displacement bytes arrive least significant first. After the last byte the decoder deasserts `byteReady` until `done`.
- R11: `done` is a single-cycle pulse, and `byteReady` is low while `done` is high.
- R12: After reset, or in the cycle after `abort`, `byteReady` is 1, `done` is 0, and any partial decode is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Discards a partial decode and returns to waiting for a new addressing-form byte |
| addr32 | input | 1 | Address size: 1 selects 32-bit forms, 0 selects 16-bit forms; sampled with the addressing-form byte |
| segOverride | input | 1 | Segment override active; sampled with the addressing-form byte |
| byteValid | input | 1 | An instruction byte is offered |
| byteData | input | 8 | Offered instruction byte |
| byteReady | output | 1 | The decoder accepts the offered byte in this cycle |
| rfIdx | output | 3 | Register file read index |
| rfData | input | REG_W | Register file read data for `rfIdx` |
| done | output | 1 | One-cycle pulse: the descriptor outputs are valid |
| regField | output | 3 | Reg field of the addressing-form byte |
| isMem | output | 1 | Second operand is memory |
| rmReg | output | 3 | R/m field, used as the second register index in mode 3 |
| effAddr | output | REG_W | Effective address |
| useStack | output | 1 | Default segment is the stack segment |

## Verification
The bench sweeps every mode and r/m value under both address sizes and both override settings. It also sweeps all 256 scale-index-base bytes under each memory mode. Register values carry set upper halves, and displacements carry both sign polarities, so these mistakes show up: a 16-bit address that is not truncated, a displacement that is zero-extended where it should be sign-extended, or displacement bytes assembled in the wrong order. The special encodings get separate coverage: index 4, base 5 in mode 0, r/m 5 in mode 0, and 16-bit r/m 6 in mode 0. A design that got these wrong would either add a stale register or ask for the wrong number of displacement bytes; the bench catches the second case as a request for an extra byte or as a stall. Abort is applied in the middle of a displacement and again after a scale-index-base byte, to show that no byte of a discarded stream leaks into the next decode.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int RIDX_W = 3;
  localparam int DISP_BYTES = 4;
  localparam int DCNT_W = $clog2(DISP_BYTES + 1);

  localparam logic [RIDX_W-1:0] GR_BX = 3'd3;
  localparam logic [RIDX_W-1:0] GR_SP = 3'd4;
  localparam logic [RIDX_W-1:0] GR_BP = 3'd5;
  localparam logic [RIDX_W-1:0] GR_SI = 3'd6;
  localparam logic [RIDX_W-1:0] GR_DI = 3'd7;

  typedef enum logic [2:0] {
    ST_MODRM, ST_SIB, ST_DISP, ST_BASE, ST_INDEX, ST_DONE
  } eaState_t;

  typedef struct packed {
    logic ldModrm;
    logic ldSib;
    logic ldDisp;
    logic ldBase;
    logic ldIndex;
    logic selIndex;
  } eaStrobe_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      abort,
  input  logic      addr32,
  input  logic      byteValid,
  input  logic [7:0] byteData,
  input  logic      dispDone,
  output eaStrobe_t strb,
  output logic      byteReady,
  output logic      done
);
  eaState_t state, stateNxt;
  logic takeByte;

  assign byteReady = (state == ST_MODRM) || (state == ST_SIB) ||
                     ((state == ST_DISP) && !dispDone);
  assign takeByte  = byteReady && byteValid && !abort;
  assign done      = (state == ST_DONE);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_MODRM: if (takeByte) begin
        strb.ldModrm = 1'b1;
        if (byteData[7:6] == 2'd3)                 stateNxt = ST_DONE;
        else if (addr32 && byteData[2:0] == GR_SP) stateNxt = ST_SIB;
        else                                       stateNxt = ST_DISP;
      end
      ST_SIB: if (takeByte) begin
        strb.ldSib = 1'b1;
        stateNxt   = ST_DISP;
      end
      ST_DISP: begin
        if (dispDone)      stateNxt = ST_BASE;
        else if (takeByte) strb.ldDisp = 1'b1;
      end
      ST_BASE: begin
        strb.ldBase = 1'b1;
        stateNxt    = ST_INDEX;
      end
      ST_INDEX: begin
        strb.ldIndex  = 1'b1;
        strb.selIndex = 1'b1;
        stateNxt      = ST_DONE;
      end
      default: stateNxt = ST_MODRM;
    endcase
    if (abort) begin
      stateNxt = ST_MODRM;
      strb     = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_MODRM;
    else       state <= stateNxt;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !byteReady); // R11
  AST_ABORT_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (byteReady && !done)); // R12
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobe_t         strb,
  input  logic [7:0]        byteData,
  input  logic              addr32In,
  input  logic              segOverrideIn,
  input  logic [REG_W-1:0]  rfData,
  output logic [RIDX_W-1:0] rfIdx,
  output logic              dispDone,
  output logic [2:0]        regField,
  output logic              isMem,
  output logic [2:0]        rmReg,
  output logic [REG_W-1:0]  effAddr,
  output logic              useStack
);
  localparam int SHORT_W = 16;
  localparam int DISP_W  = 8 * DISP_BYTES;

  logic [7:0]        modrmQ, sibQ;
  logic [DISP_W-1:0] dispQ;
  logic [DCNT_W-1:0] dispCnt, dispLen;
  logic [REG_W-1:0]  baseQ, idxQ, dispExt, sum32;
  logic [SHORT_W-1:0] sum16;
  logic              a32Q, ovrQ;
  logic [1:0]        modeF, scale;
  logic [2:0]        rmF, sibBase, sibIdx;
  logic              hasSib, baseEn, idxEn, stackDef;
  logic [RIDX_W-1:0] baseSel, idxSel;

  assign modeF   = modrmQ[7:6];
  assign rmF     = modrmQ[2:0];
  assign sibBase = sibQ[2:0];
  assign sibIdx  = sibQ[5:3];
  assign hasSib  = a32Q && (rmF == GR_SP) && (modeF != 2'd3);

  always_comb begin
    dispLen = '0;
    if (modeF == 2'd1)      dispLen = DCNT_W'(1);
    else if (modeF == 2'd2) dispLen = a32Q ? DCNT_W'(4) : DCNT_W'(2);
    else if (modeF == 2'd0) begin
      if (a32Q) dispLen = ((rmF == GR_BP) || (hasSib && sibBase == GR_BP)) ? DCNT_W'(4) : '0;
      else      dispLen = (rmF == 3'd6) ? DCNT_W'(2) : '0;
    end
  end
  assign dispDone = (dispCnt == dispLen);

  always_comb begin
    baseEn = 1'b0; baseSel = GR_BX;
    idxEn  = 1'b0; idxSel  = GR_SI;
    scale  = 2'd0;
    if (a32Q) begin
      if (hasSib) begin
        baseEn  = !((modeF == 2'd0) && (sibBase == GR_BP));
        baseSel = sibBase;
        idxEn   = (sibIdx != GR_SP);
        idxSel  = sibIdx;
        scale   = sibQ[7:6];
      end else begin
        baseEn  = !((modeF == 2'd0) && (rmF == GR_BP));
        baseSel = rmF;
      end
    end else begin
      unique case (rmF)
        3'd0: begin baseEn = 1'b1; baseSel = GR_BX; idxEn = 1'b1; idxSel = GR_SI; end
        3'd1: begin baseEn = 1'b1; baseSel = GR_BX; idxEn = 1'b1; idxSel = GR_DI; end
        3'd2: begin baseEn = 1'b1; baseSel = GR_BP; idxEn = 1'b1; idxSel = GR_SI; end
        3'd3: begin baseEn = 1'b1; baseSel = GR_BP; idxEn = 1'b1; idxSel = GR_DI; end
        3'd4: begin baseEn = 1'b1; baseSel = GR_SI; end
        3'd5: begin baseEn = 1'b1; baseSel = GR_DI; end
        3'd6: begin baseEn = (modeF != 2'd0); baseSel = GR_BP; end
        default: begin baseEn = 1'b1; baseSel = GR_BX; end
      endcase
    end
  end
  assign rfIdx = strb.selIndex ? idxSel : baseSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modrmQ <= 8'hC0; sibQ <= '0; a32Q <= 1'b0; ovrQ <= 1'b0;
      dispQ <= '0; dispCnt <= '0; baseQ <= '0; idxQ <= '0;
    end else begin
      if (strb.ldModrm) begin
        modrmQ <= byteData; a32Q <= addr32In; ovrQ <= segOverrideIn;
        sibQ <= '0; dispQ <= '0; dispCnt <= '0;
      end
      if (strb.ldSib) sibQ <= byteData;
      if (strb.ldDisp) begin
        dispQ[{dispCnt[1:0], 3'b000} +: 8] <= byteData;
        dispCnt <= dispCnt + 1'b1;
      end
      if (strb.ldBase)  baseQ <= baseEn ? rfData : '0;
      if (strb.ldIndex) idxQ  <= idxEn  ? rfData : '0;
    end
  end

  always_comb begin
    unique case (dispLen)
      DCNT_W'(1): dispExt = {{(REG_W-8){dispQ[7]}}, dispQ[7:0]};
      DCNT_W'(2): dispExt = {{(REG_W-16){dispQ[15]}}, dispQ[15:0]};
      DCNT_W'(4): dispExt = REG_W'(dispQ);
      default:    dispExt = '0;
    endcase
  end

  assign sum32 = baseQ + (idxQ << scale) + dispExt;
  assign sum16 = baseQ[SHORT_W-1:0] + idxQ[SHORT_W-1:0] + dispExt[SHORT_W-1:0];

  assign stackDef = a32Q ? (((rmF == GR_BP) && (modeF != 2'd0)) || (hasSib && sibBase == GR_SP))
                         : ((rmF == 3'd2) || (rmF == 3'd3) || ((rmF == 3'd6) && (modeF != 2'd0)));

  assign regField = modrmQ[5:3];
  assign rmReg    = rmF;
  assign isMem    = (modeF != 2'd3);
  assign effAddr  = !isMem ? '0 : (a32Q ? sum32 : {{(REG_W-SHORT_W){1'b0}}, sum16});
  assign useStack = isMem && !ovrQ && stackDef;

  AST_SHORT_TRUNC: assert property (@(posedge clk) disable iff (!rstN)
    !a32Q |-> (effAddr[REG_W-1:SHORT_W] == '0)); // R4
  AST_DISP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldDisp |-> (dispCnt < DCNT_W'(DISP_BYTES))); // R10
  AST_NO_SIB_IN_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldSib && !strb.ldModrm) |-> a32Q); // R7
endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
  import ea_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abort,
  input  logic              addr32,
  input  logic              segOverride,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              byteReady,
  output logic [RIDX_W-1:0] rfIdx,
  input  logic [REG_W-1:0]  rfData,
  output logic              done,
  output logic [2:0]        regField,
  output logic              isMem,
  output logic [2:0]        rmReg,
  output logic [REG_W-1:0]  effAddr,
  output logic              useStack
);
  eaStrobe_t strb;
  logic dispDone;

  ea_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .abort(abort), .addr32(addr32),
    .byteValid(byteValid), .byteData(byteData), .dispDone(dispDone),
    .strb(strb), .byteReady(byteReady), .done(done)
  );

  ea_datapath #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .addr32In(addr32), .segOverrideIn(segOverride), .rfData(rfData),
    .rfIdx(rfIdx), .dispDone(dispDone), .regField(regField), .isMem(isMem),
    .rmReg(rmReg), .effAddr(effAddr), .useStack(useStack)
  );

  AST_REG_FORM_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (done && !isMem) |-> (effAddr == '0 && !useStack)); // R2
endmodule

// File: tb/ea_decoder_bench.sv
module ea_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  logic clk = 1'b0, rstN = 1'b0, abort = 1'b0, addr32 = 1'b0, segOverride = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteReady, done, isMem, useStack;
  logic [2:0] rfIdx, regField, rmReg;
  logic [31:0] rfData, effAddr;
  logic [31:0] regs [8];

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rfData = regs[rfIdx];

  ea_decoder u_ea_decoder (
    .clk(clk), .rstN(rstN), .abort(abort), .addr32(addr32), .segOverride(segOverride),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady), .rfIdx(rfIdx),
    .rfData(rfData), .done(done), .regField(regField), .isMem(isMem), .rmReg(rmReg),
    .effAddr(effAddr), .useStack(useStack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction

  // Reference model built from the requirement text.
  task automatic model(input bit a32, input bit ovr, input logic [7:0] m, input logic [7:0] s,
                       input logic [31:0] d, output int dlen, output bit sibUsed,
                       output logic [31:0] ea, output bit stk);
    logic [1:0] md;
    logic [2:0] rm;
    logic [31:0] b, x, dv;
    logic [15:0] e16;
    md = m[7:6]; rm = m[2:0];
    dlen = 0; sibUsed = 0; ea = '0; stk = 0; b = '0; x = '0; dv = '0;
    if (md == 2'd3) return;
    if (!a32) begin
      case (rm)
        3'd0: begin b = regs[3]; x = regs[6]; end
        3'd1: begin b = regs[3]; x = regs[7]; end
        3'd2: begin b = regs[5]; x = regs[6]; end
        3'd3: begin b = regs[5]; x = regs[7]; end
        3'd4: b = regs[6];
        3'd5: b = regs[7];
        3'd6: b = (md == 2'd0) ? 32'd0 : regs[5];
        default: b = regs[3];
      endcase
      if (md == 2'd1) begin dlen = 1; dv = sx8(d[7:0]); end
      else if (md == 2'd2 || rm == 3'd6) begin dlen = 2; dv = {16'd0, d[15:0]}; end
      e16 = b[15:0] + x[15:0] + dv[15:0];
      ea = {16'd0, e16};
      stk = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'd0);
    end else if (rm == 3'd4) begin
      sibUsed = 1;
      b = (s[2:0] == 3'd5 && md == 2'd0) ? 32'd0 : regs[s[2:0]];
      x = (s[5:3] == 3'd4) ? 32'd0 : (regs[s[5:3]] << s[7:6]);
      if (md == 2'd1) begin dlen = 1; dv = sx8(d[7:0]); end
      else if (md == 2'd2 || s[2:0] == 3'd5) begin dlen = 4; dv = d; end
      ea = b + x + dv;
      stk = (s[2:0] == 3'd4);
    end else begin
      b = (rm == 3'd5 && md == 2'd0) ? 32'd0 : regs[rm];
      if (md == 2'd1) begin dlen = 1; dv = sx8(d[7:0]); end
      else if (md == 2'd2 || rm == 3'd5) begin dlen = 4; dv = d; end
      ea = b + dv;
      stk = (rm == 3'd5 && md != 2'd0);
    end
    if (ovr) stk = 0;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ok);
    int t = 0;
    @(negedge clk);
    byteValid = 1'b1; byteData = v;
    while (!byteReady && t < TMO) begin @(negedge clk); t++; end
    ok = (t < TMO);
    if (ok) @(posedge clk);
  endtask

  task automatic runDecode(input bit a32, input bit ovr, input logic [7:0] m,
                           input logic [7:0] s, input logic [31:0] d);
    int dlen, t;
    bit sibUsed, stk, ok, extra;
    logic [31:0] ea;
    string eaTag, stTag;
    model(a32, ovr, m, s, d, dlen, sibUsed, ea, stk);
    addr32 = a32; segOverride = ovr;
    sendByte(m, ok);
    if (ok && sibUsed) sendByte(s, ok);
    for (int i = 0; i < dlen; i++) if (ok) sendByte(d[8*i +: 8], ok);
    if (!ok) begin
      chk(0, "R10 byte stream stalled", {24'd0, m}, {24'd0, s});
      byteValid = 1'b0;
      return;
    end
    @(negedge clk);
    byteValid = 1'b0;
    t = 0; extra = 0;
    while (!done && t < TMO) begin
      if (byteReady) extra = 1;
      @(negedge clk); t++;
    end
    chk(!extra, "R10 extra byte requested", {31'd0, extra}, 32'd0);
    chk(done, "R11 done missing", {31'd0, done}, 32'd1);
    if (!done) return;
    chk(regField == m[5:3] && rmReg == m[2:0], "R1 fields",
        {26'd0, regField, rmReg}, {26'd0, m[5:3], m[2:0]});
    chk(isMem == (m[7:6] != 2'd3), "R1 R2 isMem", {31'd0, isMem}, {31'd0, m[7:6] != 2'd3});
    eaTag = (m[7:6] == 2'd3) ? "R2 addr" : (!a32 ? "R3 R4 addr16" : (sibUsed ? "R7 R10 sib addr" : "R6 R10 addr32"));
    chk(effAddr == ea, eaTag, effAddr, ea);
    stTag = ovr ? "R9 override" : (a32 ? "R8 stack32" : "R5 stack16");
    chk(useStack == stk, stTag, {31'd0, useStack}, {31'd0, stk});
    chk(!byteReady, "R11 ready during done", {31'd0, byteReady}, 32'd0);
    @(negedge clk);
    chk(!done, "R11 done width", {31'd0, done}, 32'd0);
  endtask

  task automatic doAbort();
    @(negedge clk);
    byteValid = 1'b0; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(byteReady && !done, "R12 after abort", {30'd0, byteReady, done}, 32'd2);
  endtask

  initial begin
    bit ok;
    for (int i = 0; i < 8; i++) regs[i] = 32'h8765_4321 ^ (i * 32'h1357_9BDF);
    repeat (3) @(negedge clk);
    chk(byteReady && !done, "R12 reset state", {30'd0, byteReady, done}, 32'd2);
    rstN = 1'b1;
    @(negedge clk);
    chk(byteReady && !done, "R12 idle after reset", {30'd0, byteReady, done}, 32'd2);

    for (int a = 0; a < 2; a++)
      for (int o = 0; o < 2; o++)
        for (int md = 0; md < 4; md++)
          for (int rm = 0; rm < 8; rm++) begin
            logic [7:0] m;
            m = {md[1:0], 3'(rm + md), rm[2:0]};
            if (a == 1 && rm == 4 && md != 3) begin
              for (int s = 0; s < 256; s++)
                if (o == 0 || s[2:0] == 3'd4 || s[2:0] == 3'd5)
                  runDecode(1'b1, o[0], m, s[7:0],
                            (32'h5A3C_96F1 ^ {4{m}}) + s * 32'h0101_0107);
            end else begin
              runDecode(a[0], o[0], m, 8'h00, (32'hE1D2_C3B4 ^ {4{m}}) + rm * 32'h0003_0081);
              runDecode(a[0], o[0], m, 8'h00, (32'h1E2D_3C4B ^ {4{m}}) + md * 32'h0900_0100);
            end
          end

    // R12: abort in the middle of a 32-bit displacement
    addr32 = 1'b1; segOverride = 1'b0;
    sendByte(8'h85, ok);
    sendByte(8'hFF, ok);
    sendByte(8'hFF, ok);
    doAbort();
    runDecode(1'b1, 1'b0, 8'hD9, 8'h00, 32'h0);
    runDecode(1'b1, 1'b0, 8'h43, 8'h00, 32'h0000_0010);
    // R12: abort after a scale-index-base byte
    sendByte(8'h44, ok);
    sendByte(8'hE4, ok);
    doAbort();
    runDecode(1'b0, 1'b0, 8'h46, 8'h00, 32'h0000_0080);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule